// File: doc/BRIEF.md
# I2C Bus Bit-Timing Generator

This block generates the SCL and SDA waveforms of an I2C master at the bit level. A byte-level sequencer asks for one bus event at a time: a START, a single data or acknowledge bit, a STOP or a repeated START. The generator plays that event on two open-drain pull-down enables and raises a one-cycle completion strobe when it is done. For a bit event it also samples the SDA pin in the middle of the SCL high phase and returns the sampled level with a valid strobe. A data bit and an acknowledge bit use the same event: writing 1 releases SDA so that the target can drive it.

Bus speed comes from one 32-bit divider word written by software. The word holds two independent 16-bit fields, one for the SCL low phase and one for the SCL high phase. Each phase lasts the field value plus one, times eight, input clocks. The block reads the word at the start of every phase, so software can rewrite it at any time without cutting a phase short. Computing the fields from a target bus rate is left to software. The generator does not detect clock stretching and does not read SCL back.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: In `div_cfg`, bits 31:16 are the high-phase field and bits 15:0 are the low-phase field.
- R2: An SCL low phase lasts (low field + 1) * 8 clock cycles and an SCL high phase lasts (high field + 1) * 8 cycles. `scl_oe` is 1 during a low phase and 0 during a high phase.
- R3: In a bit event, `sda_oe` takes the value NOT `cmd_bit` exactly (low field + 1) * 4 cycles after the command is accepted, which is the middle of the low phase.
- R4: In a bit event, the SDA pin is sampled (high field + 1) * 4 cycles into the high phase. `rx_bit` carries the level the pin had two cycles earlier (synchroniser latency), and `rx_valid` pulses for exactly one cycle.
- R5: A START keeps SCL released for (high field + 1) * 8 cycles, pulls SDA low halfway through that time, and then pulls SCL low.
- R6: A STOP pulls SDA low in the middle of a low phase, releases SCL for one high phase, and releases SDA halfway through that high phase. Afterwards both lines stay released.
- R7: A repeated START releases SDA in the middle of a low phase, then keeps SCL released for (high field + 1) * 16 cycles. It pulls SDA low (high field + 1) * 7 cycles into that stretch, which is 7/8 of the programmed high time.
- R8: `busy` is 1 from the cycle after a command is accepted until `done`. `done` is a one-cycle pulse in the cycle where `busy` returns to 0. `cmd_valid` has no effect while `busy` is 1.
- R9: The divider word is read at the start of each phase. A rewrite during a phase changes only the phases that start later.
- R10: A field value of 0 is legal and gives the shortest phase: 8 cycles, with its midpoint at cycle 4.
- R11: After reset, and whenever the block is idle after a STOP, `scl_oe`, `sda_oe`, `busy`, `done` and `rx_valid` are all 0.
- R12: Command codes on `cmd_op` are 0 for START, 1 for a bit, 2 for STOP and 3 for repeated START. After every event except STOP, SCL stays pulled low until the next command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | 32 | Divider word: high field [31:16], low field [15:0] |
| cmd_valid | input | 1 | Request an event; taken when busy is 0 |
| cmd_op | input | 2 | Event code: 0 START, 1 bit, 2 STOP, 3 repeated START |
| cmd_bit | input | 1 | Bit to place on SDA for a bit event (1 releases SDA) |
| busy | output | 1 | An event is in progress |
| done | output | 1 | One-cycle strobe when an event finishes |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA pin level |
| rx_bit | output | 1 | SDA level sampled during the last bit event |
| rx_valid | output | 1 | One-cycle strobe marking rx_bit as new |

## Verification
The assertions check handshake properties that hold on every cycle. `done` and `rx_valid` are always single-cycle pulses. `busy` can only fall together with `done`, and a command taken while idle always raises `busy`. SDA is never pulled low while both SCL and the block are idle, and a sample is only taken while SCL is released. The exact cycle on which each line changes is checked only by the bench's reference model. This covers the midpoint and 7/8 placements, the doubled high time of a repeated START, the per-phase reading of the divider word, and the zero-field shortest phase, all under the scenarios the bench drives.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

  // Event codes presented by the byte sequencer
  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_BIT    = 2'd1,
    OP_STOP   = 2'd2,
    OP_RSTART = 2'd3
  } tg_op_e;

  // Control states of the event sequencer
  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,  // both lines released
    ST_PARK   = 2'd1,  // SCL held low, waiting for the next event
    ST_FIRST  = 2'd2,  // first phase of an event
    ST_SECOND = 2'd3   // second phase of an event
  } tg_state_e;

  // Request to update one open-drain enable
  typedef struct packed {
    logic load;
    logic val;
  } pin_ctl_t;

endpackage

// File: rtl/i2c_tg_phase_timer.sv
module i2c_tg_phase_timer #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          use_high,
  input  logic          stretch,
  input  logic [2*FW-1:0] div_word,
  output logic          ev_hit,
  output logic          end_hit
);
  // f+1 times 16 needs FW+1+4 bits
  localparam int CW = FW + 5;

  logic [FW-1:0] fld;
  logic [CW-1:0] base;
  logic [CW-1:0] len_n;
  logic [CW-1:0] ev_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] ev_q;
  logic          act_q;

  // The divider word is only looked at when a phase is loaded
  assign fld  = use_high ? div_word[2*FW-1:FW] : div_word[FW-1:0];
  assign base = CW'(fld) + CW'(1);

  always_comb begin
    if (stretch) begin
      len_n = base << 4;
      ev_n  = (base << 3) - base;
    end else begin
      len_n = base << 3;
      ev_n  = base << 2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= '0;
      ev_q  <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      len_q <= len_n;
      ev_q  <= ev_n;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == len_q - CW'(1)) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign ev_hit  = act_q && (cnt_q == ev_q - CW'(1));
  assign end_hit = act_q && (cnt_q == len_q - CW'(1));

endmodule

// File: rtl/i2c_tg_seq.sv
module i2c_tg_seq
  import i2c_tg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic     cmd_bit,
  input  logic     ev_hit,
  input  logic     end_hit,
  output logic     t_start,
  output logic     t_high,
  output logic     t_stretch,
  output pin_ctl_t scl_ctl,
  output pin_ctl_t sda_ctl,
  output logic     smp,
  output logic     done,
  output logic     busy
);
  tg_state_e st_q, st_n;
  tg_op_e    op_q, op_in;
  logic      bit_q;
  logic      done_n;
  logic      take;

  assign op_in = tg_op_e'(cmd_op);
  assign take  = cmd_valid && (st_q == ST_FREE || st_q == ST_PARK);

  always_comb begin
    st_n      = st_q;
    t_start   = 1'b0;
    t_high    = 1'b0;
    t_stretch = 1'b0;
    scl_ctl   = '0;
    sda_ctl   = '0;
    smp       = 1'b0;
    done_n    = 1'b0;
    unique case (st_q)
      ST_FREE, ST_PARK: begin
        if (take) begin
          st_n    = ST_FIRST;
          t_start = 1'b1;
          t_high  = (op_in == OP_START);
          scl_ctl = '{load: 1'b1, val: (op_in != OP_START)};
        end
      end
      ST_FIRST: begin
        if (ev_hit) begin
          sda_ctl.load = 1'b1;
          unique case (op_q)
            OP_START:  sda_ctl.val = 1'b1;
            OP_BIT:    sda_ctl.val = ~bit_q;
            OP_STOP:   sda_ctl.val = 1'b1;
            OP_RSTART: sda_ctl.val = 1'b0;
          endcase
        end
        if (end_hit) begin
          if (op_q == OP_START) begin
            st_n    = ST_PARK;
            scl_ctl = '{load: 1'b1, val: 1'b1};
            done_n  = 1'b1;
          end else begin
            st_n      = ST_SECOND;
            t_start   = 1'b1;
            t_high    = 1'b1;
            t_stretch = (op_q == OP_RSTART);
            scl_ctl   = '{load: 1'b1, val: 1'b0};
          end
        end
      end
      ST_SECOND: begin
        if (ev_hit) begin
          unique case (op_q)
            OP_BIT:    smp = 1'b1;
            OP_STOP:   sda_ctl = '{load: 1'b1, val: 1'b0};
            OP_RSTART: sda_ctl = '{load: 1'b1, val: 1'b1};
            default:   smp = 1'b0;
          endcase
        end
        if (end_hit) begin
          done_n = 1'b1;
          if (op_q == OP_STOP) begin
            st_n    = ST_FREE;
            scl_ctl = '{load: 1'b1, val: 1'b0};
          end else begin
            st_n    = ST_PARK;
            scl_ctl = '{load: 1'b1, val: 1'b1};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_FREE;
      op_q  <= OP_START;
      bit_q <= 1'b1;
      done  <= 1'b0;
    end else begin
      st_q <= st_n;
      done <= done_n;
      if (take) begin
        op_q  <= op_in;
        bit_q <= cmd_bit;
      end
    end
  end

  assign busy = (st_q == ST_FIRST) || (st_q == ST_SECOND);

endmodule

// File: rtl/i2c_tg_pins.sv
module i2c_tg_pins
  import i2c_tg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  pin_ctl_t scl_ctl,
  input  pin_ctl_t sda_ctl,
  input  logic     smp,
  input  logic     sda_in,
  output logic     scl_oe,
  output logic     sda_oe,
  output logic     rx_bit,
  output logic     rx_valid
);
  logic sda_s;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_s = sda_in;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sy_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sy_q <= '1;
        end else begin
          sy_q[0] <= sda_in;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            sy_q[i] <= sy_q[i-1];
          end
        end
      end
      assign sda_s = sy_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_bit   <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      if (scl_ctl.load) scl_oe <= scl_ctl.val;
      if (sda_ctl.load) sda_oe <= sda_ctl.val;
      rx_valid <= smp;
      if (smp) rx_bit <= sda_s;
    end
  end

endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
  import i2c_tg_pkg::*;
#(
  parameter int FW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2*FW-1:0] div_cfg,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  output logic          busy,
  output logic          done,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in,
  output logic          rx_bit,
  output logic          rx_valid
);
  logic     t_start, t_high, t_stretch;
  logic     ev_hit, end_hit, smp;
  pin_ctl_t scl_ctl, sda_ctl;

  i2c_tg_phase_timer #(.FW(FW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (t_start),
    .use_high (t_high),
    .stretch  (t_stretch),
    .div_word (div_cfg),
    .ev_hit   (ev_hit),
    .end_hit  (end_hit)
  );

  i2c_tg_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bit   (cmd_bit),
    .ev_hit    (ev_hit),
    .end_hit   (end_hit),
    .t_start   (t_start),
    .t_high    (t_high),
    .t_stretch (t_stretch),
    .scl_ctl   (scl_ctl),
    .sda_ctl   (sda_ctl),
    .smp       (smp),
    .done      (done),
    .busy      (busy)
  );

  i2c_tg_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .scl_ctl  (scl_ctl),
    .sda_ctl  (sda_ctl),
    .smp      (smp),
    .sda_in   (sda_in),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid)
  );

endmodule

// File: rtl/i2c_scl_timing_gen_chk.sv
module i2c_scl_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic scl_oe,
  input logic sda_oe,
  input logic rx_valid
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_busy_falls_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_accept_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid) |=> busy);

  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_sample_scl_high_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!scl_oe && busy));

  assert_idle_release_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !scl_oe) |-> !sda_oe);

endmodule

bind i2c_scl_timing_gen i2c_scl_timing_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .rx_valid  (rx_valid)
);

// File: tb/tb_i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] div_cfg = 32'h0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_bit = 1'b1;
  logic        busy, done, scl_oe, sda_oe, rx_bit, rx_valid;
  logic        slave_pull = 1'b0;
  logic        sda_in;

  assign sda_in = ~(sda_oe | slave_pull);

  always #2 clk = ~clk;

  i2c_scl_timing_gen dut (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .busy(busy), .done(done),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- reference model (behavioural, per edge) ----------------
  int m_st, m_op, m_bit, m_cnt, m_len, m_ev;
  bit e_scl, e_sda, e_done, e_rxv, e_rx, q0, q1, rxnew;

  function automatic int fld_of(input logic [31:0] d, input bit hi);
    return hi ? int'(d[31:16]) : int'(d[15:0]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; e_scl = 0; e_sda = 0; e_done = 0; e_rxv = 0; e_rx = 1;
      m_cnt = 0; m_len = 0; m_ev = 0; q0 = 1; q1 = 1;
    end else begin
      e_done = 0; e_rxv = 0;
      rxnew = q1; q1 = q0; q0 = sda_in;
      if (m_st < 2) begin
        if (cmd_valid) begin
          m_op = int'(cmd_op); m_bit = int'(cmd_bit); m_st = 2; m_cnt = 0;
          m_len = (fld_of(div_cfg, m_op == 0) + 1) * 8;
          m_ev  = m_len / 2;
          e_scl = (m_op != 0);
        end
      end else begin
        if (m_cnt == m_ev - 1) begin
          if (m_st == 2) begin
            if (m_op == 1) e_sda = !m_bit;
            else e_sda = (m_op != 3);
          end else begin
            if (m_op == 1) begin e_rxv = 1; e_rx = rxnew; end
            else if (m_op == 2) e_sda = 0;
            else if (m_op == 3) e_sda = 1;
          end
        end
        if (m_cnt == m_len - 1) begin
          if (m_st == 2 && m_op != 0) begin
            m_st = 3; m_cnt = 0; e_scl = 0;
            m_len = (fld_of(div_cfg, 1) + 1) * ((m_op == 3) ? 16 : 8);
            m_ev  = (m_op == 3) ? (fld_of(div_cfg, 1) + 1) * 7 : m_len / 2;
          end else begin
            e_done = 1;
            if (m_op == 2) begin m_st = 0; e_scl = 0; end
            else begin m_st = 1; e_scl = 1; end
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // ---------------- per-cycle comparison and event stamps ----------------
  int  t_sda_rise, t_sda_fall, t_scl_rel, t_rx, t_done, n_done;
  bit  v_rx, p_sda, p_scl;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(scl_oe == e_scl, "R2 scl_oe", scl_oe, e_scl);
      chk(sda_oe == e_sda, "R3 sda_oe", sda_oe, e_sda);
      chk(busy == (m_st >= 2), "R8 busy", busy, m_st >= 2);
      chk(done == e_done, "R8 done", done, e_done);
      chk(rx_valid == e_rxv, "R4 rx_valid", rx_valid, e_rxv);
      if (e_rxv) chk(rx_bit == e_rx, "R4 rx_bit", rx_bit, e_rx);
    end
    if (!p_sda && sda_oe) t_sda_rise = cyc;
    if (p_sda && !sda_oe) t_sda_fall = cyc;
    if (p_scl && !scl_oe) t_scl_rel = cyc;
    if (rx_valid) begin t_rx = cyc; v_rx = rx_bit; end
    if (done) begin t_done = cyc; n_done++; end
    p_sda = sda_oe; p_scl = scl_oe;
  end

  int t_acc;

  // Issue one event; t_acc is the cycle of the accepting edge
  task automatic issue(input int op, input bit b);
    @(negedge clk);
    t_sda_rise = -1; t_sda_fall = -1; t_scl_rel = -1; t_rx = -1; t_done = -1; n_done = 0;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = b;
    @(negedge clk);
    t_acc = cyc;
    cmd_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R11 reset lines", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && done == 0 && rx_valid == 0, "R11 reset strobes",
        {busy, done, rx_valid}, 0);
    rst = 1'b0;
    div_cfg = {16'd5, 16'd2};   // high 48 cycles, low 24 cycles
    settle(3);

    // R5 / R12: START
    issue(0, 1'b1);
    settle(52);
    chk(t_sda_rise - t_acc == 24, "R5 START sda low at half high", t_sda_rise - t_acc, 24);
    chk(t_done - t_acc == 48, "R5 START length", t_done - t_acc, 48);
    chk(scl_oe == 1 && busy == 0, "R12 SCL parked low after START", scl_oe, 1);

    // R1 / R2 / R3 / R4: bit 1, target pulls SDA low (acknowledge)
    slave_pull = 1'b1;
    issue(1, 1'b1);
    settle(76);
    chk(t_sda_fall - t_acc == 12, "R3 SDA released mid low", t_sda_fall - t_acc, 12);
    chk(t_scl_rel - t_acc == 24, "R1 low field selects low time", t_scl_rel - t_acc, 24);
    chk(t_done - t_scl_rel == 48, "R2 high time from high field", t_done - t_scl_rel, 48);
    chk(t_rx - t_scl_rel == 24, "R4 sample mid high", t_rx - t_scl_rel, 24);
    chk(v_rx == 1'b0, "R4 sampled acknowledge", v_rx, 0);
    slave_pull = 1'b0;

    // R3: bit 0
    issue(1, 1'b0);
    settle(76);
    chk(t_sda_rise - t_acc == 12, "R3 SDA driven low mid low", t_sda_rise - t_acc, 12);
    chk(v_rx == 1'b0, "R4 own low bit read back", v_rx, 0);

    // R8: a command presented while busy is ignored
    issue(1, 1'b1);
    settle(10);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    settle(3);
    cmd_valid = 1'b0;
    settle(70);
    chk(n_done == 1, "R8 one done only", n_done, 1);
    chk(t_done - t_acc == 72, "R8 bit not disturbed", t_done - t_acc, 72);
    chk(v_rx == 1'b1, "R4 released line reads 1", v_rx, 1);
    chk(busy == 0 && scl_oe == 1, "R8 ignored STOP left SCL held", scl_oe, 1);

    // R7: repeated START
    issue(3, 1'b1);
    settle(124);
    chk(t_scl_rel - t_acc == 24, "R7 low phase before stretch", t_scl_rel - t_acc, 24);
    chk(t_sda_rise - t_scl_rel == 42, "R7 SDA low at 7/8 high", t_sda_rise - t_scl_rel, 42);
    chk(t_done - t_scl_rel == 96, "R7 SCL high twice high time", t_done - t_scl_rel, 96);

    // R9: divider rewrite during the low phase
    issue(1, 1'b1);
    settle(4);
    div_cfg = {16'd1, 16'd9};
    settle(44);
    chk(t_scl_rel - t_acc == 24, "R9 running low phase kept", t_scl_rel - t_acc, 24);
    chk(t_done - t_scl_rel == 16, "R9 next phase uses new word", t_done - t_scl_rel, 16);

    // R10: zero fields
    div_cfg = 32'h0;
    issue(1, 1'b0);
    settle(20);
    chk(t_sda_rise - t_acc == 4, "R10 midpoint at 4", t_sda_rise - t_acc, 4);
    chk(t_scl_rel - t_acc == 8, "R10 low phase 8", t_scl_rel - t_acc, 8);
    chk(t_rx - t_scl_rel == 4, "R10 sample at 4", t_rx - t_scl_rel, 4);
    chk(t_done - t_acc == 16, "R10 bit 16 cycles", t_done - t_acc, 16);

    // R6 / R11: STOP
    div_cfg = {16'd5, 16'd2};
    issue(2, 1'b1);
    settle(76);
    chk(t_scl_rel - t_acc == 24, "R6 SCL released after low", t_scl_rel - t_acc, 24);
    chk(t_sda_fall - t_scl_rel == 24, "R6 SDA released mid high", t_sda_fall - t_scl_rel, 24);
    chk(t_done - t_acc == 72, "R6 STOP length", t_done - t_acc, 72);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0, "R11 idle after STOP",
        {scl_oe, sda_oe, busy}, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule